// File: doc/BRIEF.md
# Companion-Chip Register File with GPIO Port

This block is a small memory-mapped peripheral of 16-bit registers behind a simple synchronous bus with address, read enable, write enable, write data and registered read data. Most registers are plain storage: control, clock divider, power, clock control, and the raw, mask and status interrupt words. A fixed, read-only status word is also included. Nothing behind these registers is modelled.

The block also drives a 16-line general-purpose port. A direction word selects which lines are outputs. A level word holds the line values. A pin is driven high only when it is an output and its level bit is high. When software writes the direction or the level word, the block compares the new effective output with the last value it recorded from such a write. For one cycle it pulses a change strobe on every pin that differs. Sixteen input lines can set or clear level bits on their own, without producing strobes.

Top module: `companion_regs`

## Requirements
- R1: Only address bits [5:0] are decoded; upper address bits are ignored. Offsets: control 0x00, clock divider 0x04, status 0x08, power 0x0C, clock control 0x10, interrupt raw 0x14, interrupt mask 0x18, interrupt status 0x1C, direction 0x20, level write 0x24, level read 0x28.
- R2: Write data is cut to its low 16 bits before storage. Every plain storage register reads back exactly what was last written.
- R3: A power write stores the value. When bit 7 of the written value is 1, bits 15 and 6 are also set, so 0x0080 reads back as 0x80C0.
- R4: The status register reads 0x0002 at all times. A bus write to offset 0x08 changes nothing and counts as an undefined access (R9).
- R5: Offsets 0x24 and 0x28 both read the full level word. A write to either offset stores the written value ANDed with the current direction word.
- R6: pin_out[i] is high exactly when level bit i and direction bit i are both 1.
- R7: After a write to the direction or level word, pin_toggle is high for exactly one cycle, in the cycle after the write, on every pin where the new effective output differs from the one recorded at the previous such write. In that same cycle pin_out already shows the new value. The new value then becomes the recorded one.
- R8: A change on pin_in[i] copies the new input value into level bit i on the following clock edge. An input change never raises pin_toggle.
- R9: A read or write at an undefined offset (unaligned, above 0x28, or a write to 0x08) returns 0 on a read, changes no register, and raises bad_access for one cycle, in the cycle after the access.
- R10: Reset clears every register except status. It also clears pin_out, pin_toggle, bad_access and bus_rdata. No strobe follows the release of reset.
- R11: bus_rdata is registered. It shows the addressed register in the cycle after bus_rd is high, reflects the state before any write in that same cycle, and holds its value while bus_rd is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address; only bits [5:0] are decoded |
| bus_rd | input | 1 | Read enable |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 32 | Write data; low 16 bits used |
| bus_rdata | output | 16 | Registered read data |
| bad_access | output | 1 | One-cycle flag for an undefined access |
| pin_in | input | 16 | Input lines that set or clear level bits |
| pin_out | output | 16 | Effective output pins (level AND direction) |
| pin_toggle | output | 16 | One-cycle per-pin change strobes |

## Verification
The port logic is exercised with three kinds of write. A level write that flips some outputs and leaves others unchanged shows that strobes appear only on the flipped pins. A direction write that leaves the effective output unchanged shows that strobes follow the effective value and not the write itself. A direction write that narrows the output set shows that the mask is applied to the output.

Input-line events are then applied to an input pin and to an output pin. The next register write is checked to see whether it compares against the recorded value or against the live pins. The register sweep writes 32-bit values with upper bits set, uses aliased upper address bits, and uses the power word with bit 7 both set and clear. It also checks the status word, unaligned offsets and out-of-range offsets, so that truncation, decoding and the power side effect are each shown apart from plain storage.

// File: rtl/companion_regs.sv
module companion_regs #(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  output logic              bad_access,
  input  logic [15:0]       pin_in,
  output logic [15:0]       pin_out,
  output logic [15:0]       pin_toggle
);
  localparam logic [5:0] OFS_CTRL = 6'h00, OFS_CDIV = 6'h04, OFS_STAT = 6'h08,
                         OFS_PWR  = 6'h0C, OFS_CLKC = 6'h10, OFS_IRAW = 6'h14,
                         OFS_IMSK = 6'h18, OFS_IST  = 6'h1C, OFS_DIR  = 6'h20,
                         OFS_LVLW = 6'h24, OFS_LVLR = 6'h28;
  localparam logic [15:0] STAT_VAL  = 16'h0002;
  localparam logic [15:0] PWR_EXTRA = 16'h8040;

  logic [15:0] ctrl_q, cdiv_q, power_q, clkc_q, iraw_q, imsk_q, ist_q;
  logic [15:0] dir_q, level_q, prev_eff_q, prev_in_q;
  logic [15:0] wd, dir_n, level_n, eff_n, rd_mux, in_chg;
  logic [5:0]  ofs;
  logic        rd_ok, wr_ok, gpio_wr;

  assign ofs   = bus_addr[5:0];
  assign wd    = bus_wdata[15:0];
  assign rd_ok = (ofs[1:0] == 2'b00) && (ofs <= OFS_LVLR);
  assign wr_ok = rd_ok && (ofs != OFS_STAT);
  assign in_chg = pin_in ^ prev_in_q;
  assign pin_out = level_q & dir_q;
  assign gpio_wr = bus_we && (ofs == OFS_DIR || ofs == OFS_LVLW || ofs == OFS_LVLR);

  always_comb begin
    dir_n   = dir_q;
    level_n = (level_q & ~in_chg) | (pin_in & in_chg);
    if (bus_we && ofs == OFS_DIR) dir_n = wd;
    if (bus_we && (ofs == OFS_LVLW || ofs == OFS_LVLR)) level_n = wd & dir_q;
    eff_n = level_n & dir_n;
  end

  always_comb begin
    case (ofs)
      OFS_CTRL: rd_mux = ctrl_q;
      OFS_CDIV: rd_mux = cdiv_q;
      OFS_STAT: rd_mux = STAT_VAL;
      OFS_PWR:  rd_mux = power_q;
      OFS_CLKC: rd_mux = clkc_q;
      OFS_IRAW: rd_mux = iraw_q;
      OFS_IMSK: rd_mux = imsk_q;
      OFS_IST:  rd_mux = ist_q;
      OFS_DIR:  rd_mux = dir_q;
      OFS_LVLW, OFS_LVLR: rd_mux = level_q;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0; cdiv_q <= '0; power_q <= '0; clkc_q <= '0;
      iraw_q <= '0; imsk_q <= '0; ist_q <= '0;
      dir_q <= '0; level_q <= '0; prev_eff_q <= '0; prev_in_q <= '0;
      bus_rdata <= '0; bad_access <= 1'b0; pin_toggle <= '0;
    end else begin
      prev_in_q  <= pin_in;
      dir_q      <= dir_n;
      level_q    <= level_n;
      bad_access <= (bus_rd && !rd_ok) || (bus_we && !wr_ok);
      pin_toggle <= '0;
      if (bus_rd) bus_rdata <= rd_mux;
      if (gpio_wr) begin
        pin_toggle <= eff_n ^ prev_eff_q;
        prev_eff_q <= eff_n;
      end
      if (bus_we) begin
        case (ofs)
          OFS_CTRL: ctrl_q  <= wd;
          OFS_CDIV: cdiv_q  <= wd;
          OFS_PWR:  power_q <= wd[7] ? (wd | PWR_EXTRA) : wd;
          OFS_CLKC: clkc_q  <= wd;
          OFS_IRAW: iraw_q  <= wd;
          OFS_IMSK: imsk_q  <= wd;
          OFS_IST:  ist_q   <= wd;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/companion_regs_chk.sv
module companion_regs_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rd,
  input logic              bus_we,
  input logic [31:0]       bus_wdata,
  input logic [15:0]       bus_rdata,
  input logic              bad_access,
  input logic [15:0]       pin_toggle,
  input logic [15:0]       power_q
);
  logic [5:0] a;
  logic       legal, gpio_hit, was_gpio_wr, was_bad;
  assign a        = bus_addr[5:0];
  assign legal    = (a[1:0] == 2'b00) && (a <= 6'h28);
  assign gpio_hit = bus_we && (a == 6'h20 || a == 6'h24 || a == 6'h28);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      was_gpio_wr <= 1'b0;
      was_bad     <= 1'b0;
    end else begin
      was_gpio_wr <= gpio_hit;
      was_bad     <= (bus_rd && !legal) || (bus_we && (!legal || a == 6'h08));
    end
  end

  // R7
  strobe_after_gpio_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_toggle != 16'h0) |-> was_gpio_wr);

  // R3
  power_extra_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && a == 6'h0C && bus_wdata[7]) |=> (power_q[15] && power_q[6]));

  // R4
  status_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && a == 6'h08) |=> (bus_rdata == 16'h0002));

  // R9
  undefined_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !legal) |=> (bus_rdata == 16'h0 && bad_access));

  // R9
  bad_flag_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_access |-> was_bad);
endmodule

bind companion_regs companion_regs_chk #(.ADDR_W(ADDR_W)) chk (.*);

// File: tb/companion_regs_test.sv
`timescale 1ns/100ps
module companion_regs_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic        bus_rd = 1'b0, bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [15:0] bus_rdata, pin_in = '0, pin_out, pin_toggle;
  logic        bad_access;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  companion_regs uut (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bad_access(bad_access),
    .pin_in(pin_in), .pin_out(pin_out), .pin_toggle(pin_toggle));

  typedef struct packed {
    logic        rd;
    logic [11:0] addr;
    logic [31:0] data;
    logic [15:0] exp;
    logic        bad;
  } vec_t;

  localparam int NV = 28;
  localparam vec_t VECS [NV] = '{
    {1'b1, 12'h008, 32'h0, 16'h0002, 1'b0},        // R4 status
    {1'b0, 12'h000, 32'h0001_ABCD, 16'h0, 1'b0},   // R2 truncation
    {1'b1, 12'h000, 32'h0, 16'hABCD, 1'b0},
    {1'b0, 12'h104, 32'hFFFF_1234, 16'h0, 1'b0},   // R1 aliased upper bits
    {1'b1, 12'h004, 32'h0, 16'h1234, 1'b0},
    {1'b1, 12'hF84, 32'h0, 16'h1234, 1'b0},        // R1
    {1'b0, 12'h00C, 32'h0000_0080, 16'h0, 1'b0},   // R3
    {1'b1, 12'h00C, 32'h0, 16'h80C0, 1'b0},
    {1'b0, 12'h00C, 32'h0000_0001, 16'h0, 1'b0},   // R3 bit7 clear
    {1'b1, 12'h00C, 32'h0, 16'h0001, 1'b0},
    {1'b0, 12'h010, 32'h0000_5555, 16'h0, 1'b0},
    {1'b0, 12'h014, 32'h0000_0F0F, 16'h0, 1'b0},
    {1'b0, 12'h018, 32'h0000_00FF, 16'h0, 1'b0},
    {1'b0, 12'h01C, 32'h0000_F00F, 16'h0, 1'b0},
    {1'b1, 12'h010, 32'h0, 16'h5555, 1'b0},        // R2
    {1'b1, 12'h014, 32'h0, 16'h0F0F, 1'b0},
    {1'b1, 12'h018, 32'h0, 16'h00FF, 1'b0},
    {1'b1, 12'h01C, 32'h0, 16'hF00F, 1'b0},
    {1'b0, 12'h008, 32'h0000_FFFF, 16'h0, 1'b1},   // R4 write is undefined
    {1'b1, 12'h008, 32'h0, 16'h0002, 1'b0},
    {1'b1, 12'h02C, 32'h0, 16'h0000, 1'b1},        // R9 out of range
    {1'b1, 12'h001, 32'h0, 16'h0000, 1'b1},        // R9 unaligned
    {1'b0, 12'h002, 32'h0000_7777, 16'h0, 1'b1},   // R9 unaligned write
    {1'b1, 12'h000, 32'h0, 16'hABCD, 1'b0},        // R9 no state change
    {1'b0, 12'h020, 32'h0000_00FF, 16'h0, 1'b0},
    {1'b0, 12'h024, 32'h0000_FFFF, 16'h0, 1'b0},   // R5 masked store
    {1'b1, 12'h028, 32'h0, 16'h00FF, 1'b0},        // R5 alias
    {1'b1, 12'h024, 32'h0, 16'h00FF, 1'b0}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic access(input logic rd, input logic [11:0] a, input logic [31:0] d);
    bus_rd = rd; bus_we = !rd; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_rd = 1'b0; bus_we = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state, no strobe on release
    check("R10 rdata", bus_rdata, 16'h0);
    check("R10 pin_out", pin_out, 16'h0);
    check("R10 pin_toggle", pin_toggle, 16'h0);
    check("R10 bad", {15'h0, bad_access}, 16'h0);

    for (int i = 0; i < NV; i++) begin
      access(VECS[i].rd, VECS[i].addr, VECS[i].data);
      if (VECS[i].rd) check($sformatf("R1/R2 vector %0d rdata", i), bus_rdata, VECS[i].exp);
      check($sformatf("R9 vector %0d bad", i), {15'h0, bad_access}, {15'h0, VECS[i].bad});
    end

    // R11 hold while bus_rd low
    @(negedge clk);
    check("R11 hold", bus_rdata, 16'h00FF);
    check("R6 out", pin_out, 16'h00FF);

    // R7 level write flips some pins, strobe with new output
    access(1'b0, 12'h024, 32'h0000_000F);
    check("R7 strobe", pin_toggle, 16'h00F0);
    check("R7 out", pin_out, 16'h000F);
    @(negedge clk);
    check("R7 one cycle", pin_toggle, 16'h0);

    // R7 direction write, effective output unchanged
    access(1'b0, 12'h020, 32'h0000_0F0F);
    check("R7 no change", pin_toggle, 16'h0);
    check("R6 out dir", pin_out, 16'h000F);

    // R7 direction narrows outputs
    access(1'b0, 12'h020, 32'h0000_0003);
    check("R7 narrow", pin_toggle, 16'h000C);
    check("R6 narrow out", pin_out, 16'h0003);

    // R8 input on a non-output pin
    pin_in = 16'h0100;
    @(negedge clk);
    check("R8 no strobe", pin_toggle, 16'h0);
    check("R8 out", pin_out, 16'h0003);
    access(1'b1, 12'h028, 32'h0);
    check("R8 level", bus_rdata, 16'h010F);

    // R8 input on an output pin drops it (line 0 rises then falls)
    pin_in = 16'h0101;
    @(negedge clk);
    pin_in = 16'h0100;
    @(negedge clk);
    check("R8 clear out", pin_out, 16'h0002);
    check("R8 clear no strobe", pin_toggle, 16'h0);

    // R7 compare uses value recorded at last write
    access(1'b0, 12'h020, 32'h0000_0003);
    check("R7 recorded", pin_toggle, 16'h0001);

    // R5 write through read offset
    access(1'b0, 12'h028, 32'h0000_FFFF);
    check("R5 out", pin_out, 16'h0003);
    check("R7 via read ofs", pin_toggle, 16'h0001);

    // R11 read shows pre-write state when same cycle
    bus_rd = 1'b1; bus_we = 1'b1; bus_addr = 12'h000; bus_wdata = 32'h0000_1111;
    @(negedge clk);
    bus_rd = 1'b0; bus_we = 1'b0;
    check("R11 pre-write", bus_rdata, 16'hABCD);

    // R10 mid-run reset
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    pin_in = 16'h0;
    @(negedge clk);
    check("R10 out", pin_out, 16'h0);
    check("R10 toggle", pin_toggle, 16'h0);
    access(1'b1, 12'h000, 32'h0);
    check("R10 ctrl", bus_rdata, 16'h0);
    access(1'b1, 12'h008, 32'h0);
    check("R10 status", bus_rdata, 16'h0002);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule